// File: doc/BRIEF.md
# Byte-Bus Serial Port with Buffered Transmit and Receive

This block is an asynchronous serial transceiver that sits on an 8-bit Wishbone slave port with a 2-bit word address. Software writes bytes into a transmit queue and reads received bytes from a receive queue, both through the same data address. A 16-bit clock divisor, split into two byte registers, sets the line rate. Each bit on the line lasts sixteen divisor ticks, so the divisor is the clock frequency divided by sixteen times the baud rate, rounded, minus one.

Accesses to the data address are blocking. A write stays pending, with acknowledge held low, while the transmit queue is full. A read stays pending while the receive queue is empty. All other addresses acknowledge at once. A status byte reports the fill state of both queues. Software can discard stale input by reading the data address until the data-present flag clears.

Framing is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line rests high. The receiver checks the start bit halfway through it and samples every later bit at its centre. It discards a frame whose stop bit reads low, and it drops a frame that arrives while its queue is full.

Top module: `serial_port_wb`

## Requirements
- R1: After reset, acknowledge is low, the serial output is high, the status byte reads 0x00, and the divisor reads back as 0x001A (low byte 0x1A at address 2, high byte 0x00 at address 3).
- R2: A write to address 2 or 3 sets the low or high byte of the divisor, and a read of the same address returns the stored byte.
- R3: The status byte at address 1 has these bits: bit 0 receive queue full, bit 1 receive queue holds 8 or more, bit 2 receive queue not empty, bit 4 transmit queue full, bit 5 transmit queue holds 8 or more. Bits 3, 6 and 7 read 0.
- R4: An access that is not stalled is acknowledged on the first rising edge after the request is seen. Acknowledge is a single-cycle pulse.
- R5: The transmitter sends a start bit at 0, eight data bits LSB first, and a stop bit at 1. Each bit lasts 16*(divisor+1) clocks, and the line is high whenever the transmitter is idle.
- R6: The transmit queue holds 16 bytes in addition to the byte being shifted out. A write to address 0 while the queue is full is not acknowledged until a slot frees, and the byte is then sent in order.
- R7: A correctly framed byte received at the programmed rate enters the receive queue, and reads of address 0 return received bytes in arrival order, one per read.
- R8: A read of address 0 while the receive queue is empty is not acknowledged until a byte arrives, and it then returns that byte.
- R9: A frame whose stop bit is low does not enter the receive queue.
- R10: A frame that completes while the receive queue holds 16 bytes is dropped, and the 16 stored bytes stay intact.
- R11: The half-full flags switch on when a queue holds 8 entries and stay off at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe, qualifies this slave's access |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 2 | Register address: 0 data, 1 status, 2 divisor low, 3 divisor high |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid while acknowledge is high |
| wb_ack_o | output | 1 | Access acknowledge |
| ser_rx_i | input | 1 | Serial receive line, asynchronous |
| ser_tx_o | output | 1 | Serial transmit line |

## Verification
Register and status accesses are due one clock after the request is seen. The bus task counts the edges until acknowledge and checks that this count is 1, or that it is well above 1 when a stall is expected. A transmitted bit lasts 32 clocks at the divisor the bench uses. The monitor finds the falling start edge, waits half a bit, and then samples each bit one bit period apart, so every sample falls near a bit centre. A received byte shows in the status byte partway through its stop bit. The bench reads status only after driving the whole stop bit and a bit of idle line, which leaves margin for the two-stage input synchroniser.

// File: rtl/spw_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial port: register addresses,
// status bit positions and the receiver state encoding.
package spw_pkg;
    localparam logic [1:0] ADR_DATA   = 2'd0;
    localparam logic [1:0] ADR_STATUS = 2'd1;
    localparam logic [1:0] ADR_DIV_LO = 2'd2;
    localparam logic [1:0] ADR_DIV_HI = 2'd3;

    localparam int ST_RX_FULL  = 0;
    localparam int ST_RX_HALF  = 1;
    localparam int ST_RX_AVAIL = 2;
    localparam int ST_TX_FULL  = 4;
    localparam int ST_TX_HALF  = 5;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/spw_fifo.sv
`timescale 1ns/1ps
// Synchronous first-in first-out queue with an occupancy count.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are ignored. The head entry is presented combinationally.
module spw_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    // Storage array write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/spw_tick_gen.sv
`timescale 1ns/1ps
// Oversampling tick source: one-cycle pulse every (div+1) clocks.
// A restart request clears the count so a new divisor takes effect
// from a known phase.
module spw_tick_gen #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    input  logic          restart,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = (cnt == div);

    // Count up to the divisor, wrap, or restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (tick)         cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spw_tx.sv
`timescale 1ns/1ps
// Transmit serialiser. Takes a byte from the queue whenever idle and
// shifts out start, eight data bits LSB first, and stop, each bit held
// for OVS ticks. Assumes tick is a single-cycle pulse.
module spw_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          have_data,
    input  logic [DW-1:0] data,
    output logic          take,
    output logic          line,
    output logic          busy
);
    localparam int FW = DW + 2;
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(FW + 1);

    logic [FW-1:0] shreg;
    logic [SW-1:0] sub;
    logic [BW-1:0] bits_left;

    assign take = !busy && have_data;
    assign line = busy ? shreg[0] : 1'b1;

    // Frame loading and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            sub       <= '0;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (take) begin
            shreg     <= {1'b1, data, 1'b0};
            sub       <= '0;
            bits_left <= BW'(FW);
            busy      <= 1'b1;
        end else if (busy && tick) begin
            if (sub == SW'(OVS - 1)) begin
                sub       <= '0;
                shreg     <= {1'b1, shreg[FW-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == BW'(1)) busy <= 1'b0;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spw_rx.sv
`timescale 1ns/1ps
// Receive sampler. Synchronises the line, confirms a start bit halfway
// through it, then samples each bit at its centre. Emits a one-cycle
// done pulse with the byte only when the stop bit reads high.
// Assumes tick is a single-cycle pulse at OVS times the bit rate.
module spw_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line_async,
    output logic          done,
    output logic [DW-1:0] data
);
    import spw_pkg::*;
    localparam int SW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    logic [1:0]    sync;
    logic          rx_s;
    rx_state_t     state;
    logic [SW-1:0] sub;
    logic [IW-1:0] idx;

    assign rx_s = sync[1];

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], line_async};
    end

    // Frame state machine, advanced on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            idx   <= '0;
            data  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        sub <= '0;
                        idx <= '0;
                        if (!rx_s) state <= RX_START;
                    end
                    RX_START: begin
                        if (sub == SW'(OVS/2 - 1)) begin
                            sub   <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (sub == SW'(OVS - 1)) begin
                            sub  <= '0;
                            data <= {rx_s, data[DW-1:1]};
                            idx  <= idx + 1'b1;
                            if (idx == IW'(DW - 1)) state <= RX_STOP;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (sub == SW'(OVS - 1)) begin
                            done  <= rx_s;
                            state <= RX_IDLE;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_port_wb.sv
`timescale 1ns/1ps
// Serial port on an 8-bit Wishbone slave. Address 0 is the blocking data
// pipe, 1 the status byte, 2/3 the divisor bytes. Data accesses are held
// (no acknowledge) while the transmit queue is full or the receive queue
// is empty. Assumes the master drops its strobe after each acknowledge.
module serial_port_wb #(
    parameter int          DW       = 8,
    parameter int          DIVW     = 16,
    parameter int          DEPTH    = 16,
    parameter int          OVS      = 16,
    parameter logic [15:0] DIV_INIT = 16'h001A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_cyc_i,
    input  logic          wb_stb_i,
    input  logic          wb_we_i,
    input  logic [1:0]    wb_adr_i,
    input  logic [DW-1:0] wb_dat_i,
    output logic [DW-1:0] wb_dat_o,
    output logic          wb_ack_o,
    input  logic          ser_rx_i,
    output logic          ser_tx_o
);
    import spw_pkg::*;
    localparam int LW = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic [DIVW-1:0] divisor;
    logic            req, div_restart, tick;
    logic            tx_push, tx_full, tx_empty, tx_take, tx_busy;
    logic [DW-1:0]   tx_head;
    logic [LW-1:0]   tx_level;
    logic            rx_pop, rx_full, rx_empty, rx_done, rx_push;
    logic [DW-1:0]   rx_head, rx_byte;
    logic [LW-1:0]   rx_level;
    logic [DW-1:0]   status;

    assign req         = wb_cyc_i && wb_stb_i && !wb_ack_o;
    assign tx_push     = req && wb_we_i && (wb_adr_i == ADR_DATA) && !tx_full;
    assign rx_pop      = req && !wb_we_i && (wb_adr_i == ADR_DATA) && !rx_empty;
    assign div_restart = req && wb_we_i &&
                         ((wb_adr_i == ADR_DIV_LO) || (wb_adr_i == ADR_DIV_HI));
    assign rx_push     = rx_done && !rx_full;

    // Assemble the status byte from queue states.
    always_comb begin
        status              = '0;
        status[ST_RX_FULL]  = rx_full;
        status[ST_RX_HALF]  = (rx_level >= LW'(HALF));
        status[ST_RX_AVAIL] = !rx_empty;
        status[ST_TX_FULL]  = tx_full;
        status[ST_TX_HALF]  = (tx_level >= LW'(HALF));
    end

    // Bus decode, register writes, read data and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
            divisor  <= DIVW'(DIV_INIT);
        end else begin
            wb_ack_o <= 1'b0;
            if (req) begin
                unique case (wb_adr_i)
                    ADR_DATA: begin
                        if (wb_we_i) begin
                            wb_ack_o <= !tx_full;
                        end else if (!rx_empty) begin
                            wb_ack_o <= 1'b1;
                            wb_dat_o <= rx_head;
                        end
                    end
                    ADR_STATUS: begin
                        wb_ack_o <= 1'b1;
                        wb_dat_o <= status;
                    end
                    ADR_DIV_LO: begin
                        wb_ack_o <= 1'b1;
                        if (wb_we_i) divisor[7:0] <= wb_dat_i;
                        else         wb_dat_o     <= divisor[7:0];
                    end
                    ADR_DIV_HI: begin
                        wb_ack_o <= 1'b1;
                        if (wb_we_i) divisor[DIVW-1:8] <= wb_dat_i[DIVW-9:0];
                        else         wb_dat_o          <= DW'(divisor[DIVW-1:8]);
                    end
                endcase
            end
        end
    end

    spw_tick_gen #(.DW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(divisor),
        .restart(div_restart), .tick(tick)
    );

    spw_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wb_dat_i),
        .pop(tx_take), .dout(tx_head), .full(tx_full), .empty(tx_empty),
        .level(tx_level)
    );

    spw_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .have_data(!tx_empty),
        .data(tx_head), .take(tx_take), .line(ser_tx_o), .busy(tx_busy)
    );

    spw_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_async(ser_rx_i),
        .done(rx_done), .data(rx_byte)
    );

    spw_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty),
        .level(rx_level)
    );
endmodule

// File: rtl/spw_checker.sv
`timescale 1ns/1ps
// Protocol and state checks for serial_port_wb, attached by bind.
module spw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wb_cyc_i,
    input logic       wb_stb_i,
    input logic       wb_we_i,
    input logic [1:0] wb_adr_i,
    input logic [7:0] wb_dat_o,
    input logic       wb_ack_o,
    input logic       ser_tx_o,
    input logic       tx_busy,
    input logic       tx_full,
    input logic       rx_empty
);
    p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o);

    p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

    p_idle_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_tx_o);

    p_write_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_i && wb_stb_i && wb_we_i && wb_adr_i == 2'd0 && tx_full && !wb_ack_o)
        |=> !wb_ack_o);

    p_read_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_i && wb_stb_i && !wb_we_i && wb_adr_i == 2'd0 && rx_empty && !wb_ack_o)
        |=> !wb_ack_o);

    p_status_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o && $past(!wb_we_i && wb_adr_i == 2'd1))
        |-> (wb_dat_o[3] == 1'b0 && wb_dat_o[7:6] == 2'b00));
endmodule

bind serial_port_wb spw_checker u_spw_checker (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
    .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_dat_o(wb_dat_o),
    .wb_ack_o(wb_ack_o), .ser_tx_o(ser_tx_o), .tx_busy(tx_busy),
    .tx_full(tx_full), .rx_empty(rx_empty)
);

// File: tb/serial_port_wb_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: bus writes to the data pipe queue expected bytes,
// a line monitor decodes frames and compares them in order.
module serial_port_wb_tb_top;
    localparam int DIV = 1;
    localparam int BP  = 16 * (DIV + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [1:0] adr = 2'd0;
    logic [7:0] dat_w = 8'd0;
    logic [7:0] dat_r;
    logic       ack;
    logic       rx_line = 1'b1;
    logic       tx_line;

    int checks = 0;
    int fails  = 0;
    logic [7:0] tx_exp[$];

    always #2.5 clk = ~clk;

    serial_port_wb dut_i (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb),
        .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dat_w), .wb_dat_o(dat_r),
        .wb_ack_o(ack), .ser_rx_i(rx_line), .ser_tx_o(tx_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
    endtask

    // One bus access; returns read data and edges waited for acknowledge.
    task automatic bus(input bit w, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] q, output int waited);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_w = d;
        waited = 0;
        do begin
            @(posedge clk); #1;
            waited++;
        end while (!ack);
        q = dat_r;
        if (w && a == 2'd0) tx_exp.push_back(d);
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] s);
        int w;
        bus(1'b0, 2'd1, 8'd0, s, w);
    endtask

    // Drive one frame onto the receive line, then one bit of idle.
    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (BP) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BP) @(negedge clk);
        end
        rx_line = stop_ok;
        repeat (BP) @(negedge clk);
        rx_line = 1'b1;
        repeat (BP) @(negedge clk);
    endtask

    // Line monitor: decode each frame and compare with the expected queue (R5).
    initial begin
        forever begin
            logic [7:0] got;
            logic       st, sp;
            @(negedge tx_line);
            repeat (BP/2) @(negedge clk);
            st = tx_line;
            for (int i = 0; i < 8; i++) begin
                repeat (BP) @(negedge clk);
                got[i] = tx_line;
            end
            repeat (BP) @(negedge clk);
            sp = tx_line;
            check(st == 1'b0, "R5 start bit", st, 0);
            check(sp == 1'b1, "R5 stop bit", sp, 1);
            if (tx_exp.size() == 0) begin
                check(1'b0, "R5 unexpected frame", got, 0);
            end else begin
                logic [7:0] e;
                e = tx_exp.pop_front();
                check(got == e, "R5/R6 tx byte order", got, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1-all actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] q, s;
        int w;

        repeat (4) @(posedge clk);
        #1;
        check(ack == 1'b0, "R1 ack in reset", ack, 0);
        check(tx_line == 1'b1, "R1 line idle", tx_line, 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R4 reset readbacks and latency.
        bus(1'b0, 2'd1, 8'd0, s, w);
        check(s == 8'h00, "R1 status after reset", s, 8'h00);
        check(w == 1, "R4 status latency", w, 1);
        bus(1'b0, 2'd2, 8'd0, q, w);
        check(q == 8'h1A, "R1 divisor low", q, 8'h1A);
        bus(1'b0, 2'd3, 8'd0, q, w);
        check(q == 8'h00, "R1 divisor high", q, 8'h00);

        // R2 divisor programming with readback.
        bus(1'b1, 2'd3, 8'h5C, q, w);
        bus(1'b0, 2'd3, 8'd0, q, w);
        check(q == 8'h5C, "R2 high byte readback", q, 8'h5C);
        bus(1'b1, 2'd3, 8'h00, q, w);
        bus(1'b1, 2'd2, 8'(DIV), q, w);
        check(w == 1, "R4 write latency", w, 1);
        bus(1'b0, 2'd2, 8'd0, q, w);
        check(q == 8'(DIV), "R2 low byte readback", q, DIV);

        // R5 single frame.
        bus(1'b1, 2'd0, 8'hA5, q, w);
        check(w == 1, "R4 data write latency", w, 1);
        wait (tx_exp.size() == 0);
        repeat (BP) @(negedge clk);

        // R6 / R11 transmit queue filling and stall.
        for (int i = 0; i < 9; i++) bus(1'b1, 2'd0, 8'(8'h10 + i), q, w);
        read_status(s);
        check(s == 8'h20, "R11 tx half at 8", s, 8'h20);
        for (int i = 9; i < 17; i++) bus(1'b1, 2'd0, 8'(8'h10 + i), q, w);
        read_status(s);
        check(s == 8'h30, "R3/R6 tx full and half", s, 8'h30);
        bus(1'b1, 2'd0, 8'h99, q, w);
        check(w > 50, "R6 write stalled while full", w, 51);
        wait (tx_exp.size() == 0);
        repeat (BP) @(negedge clk);
        read_status(s);
        check(s == 8'h00, "R3 tx drained", s, 8'h00);

        // R7 one received byte.
        send_frame(8'hC3, 1'b1);
        read_status(s);
        check(s == 8'h04, "R3/R7 data present", s, 8'h04);
        bus(1'b0, 2'd0, 8'd0, q, w);
        check(q == 8'hC3, "R7 received byte", q, 8'hC3);
        check(w == 1, "R4 data read latency", w, 1);

        // R9 bad stop bit.
        send_frame(8'h5A, 1'b0);
        read_status(s);
        check(s == 8'h00, "R9 bad frame discarded", s, 8'h00);

        // R8 read stall until a byte arrives.
        fork
            bus(1'b0, 2'd0, 8'd0, q, w);
            begin
                repeat (60) @(negedge clk);
                send_frame(8'h3C, 1'b1);
            end
        join
        check(q == 8'h3C, "R8 stalled read data", q, 8'h3C);
        check(w > 60, "R8 read stalled", w, 61);

        // R10 / R11 receive queue filling and overflow.
        for (int i = 0; i < 17; i++) begin
            send_frame(8'(8'h40 + i), 1'b1);
            if (i == 6) begin
                read_status(s);
                check(s == 8'h04, "R11 rx at 7 not half", s, 8'h04);
            end
            if (i == 7) begin
                read_status(s);
                check(s == 8'h06, "R11 rx half at 8", s, 8'h06);
            end
            if (i == 15) begin
                read_status(s);
                check(s == 8'h07, "R3 rx full", s, 8'h07);
            end
        end
        read_status(s);
        check(s == 8'h07, "R10 still full after overflow", s, 8'h07);
        for (int i = 0; i < 16; i++) begin
            bus(1'b0, 2'd0, 8'd0, q, w);
            check(q == 8'(8'h40 + i), "R7/R10 rx order", q, 8'h40 + i);
        end
        read_status(s);
        check(s == 8'h00, "R10 overflow byte dropped", s, 8'h00);

        repeat (20) @(negedge clk);
        check(tx_exp.size() == 0, "R5 pending tx", tx_exp.size(), 0);
        summary();
        $finish;
    end
endmodule